// File: doc/BRIEF.md
# Segment Address Translation and Protection Unit

This unit turns a (segment index, offset) reference into a linear address and decides whether the reference is legal. It holds six segment descriptors. Each descriptor has a base, a byte length, read/write/execute permission bits and a present flag. The table is written through a descriptor-load port, and requests arrive on a one-beat request port. One cycle later a registered response reports either an address with a valid strobe or a fault code.

The unit has three operating modes. Legacy mode applies no checks. It forms a 20-bit address from a 16-bit selector, taken from the low half of the descriptor base, shifted left by four bits, plus a 16-bit offset. Protected mode adds the base to the offset and checks the present flag, the permissions and the length. Flat mode treats segments 0 to 3 as zero-based and unbounded. Segments 4 and 5 keep their own bases. Present and permission checks still apply in flat mode.

The unit leaves reset in legacy mode. Software must write a mode code to move it into protected or flat mode.

Top module: `segxlat_unit`

## Requirements
- R1: After reset the mode reads as legacy (code 0), no response is valid, and all six descriptors are cleared: base 0, length 0, no permissions, not present.
- R2: The mode codes are 0 legacy, 1 protected and 2 flat. A mode write with code 3 is ignored. A mode write applies to requests issued in later cycles, not to a request issued in the same cycle.
- R3: Each request produces exactly one response in the following cycle. The address valid strobe is high only when the fault code is 0. A faulting response drives the address to zero.
- R4: In legacy mode the address is ((base[15:0] << 4) + offset[15:0]) modulo 2^20. No fault is ever reported in this mode, whatever the present flag, the permissions or the length.
- R5: In protected mode the address is (base + offset) modulo 2^32.
- R6: In protected mode an offset greater than or equal to the length gives a limit fault (code 1).
- R7: Permission bit 0 grants read (type 0), bit 1 grants write (type 1) and bit 2 grants fetch (type 2). Request type 3 has no grant. A missing grant gives a permission fault (code 2), which takes priority over a limit fault.
- R8: A reference to a descriptor whose present flag is clear gives a not-present fault (code 3), which takes priority over all other faults.
- R9: In flat mode, segments 0 to 3 use base 0, segments 4 and 5 use their own base, and no limit check is made for any segment. Present and permission checks still apply.
- R10: Index 6 or 7 gives a not-present fault in protected and flat modes. In legacy mode it acts as selector 0.
- R11: A descriptor load writes the indexed entry and is visible to a request issued in the next cycle. A load to index 6 or 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 2 | Mode code to write |
| mode_o | output | 2 | Current mode |
| ld_en | input | 1 | Descriptor load strobe |
| ld_idx | input | 3 | Descriptor index to load |
| ld_base | input | 32 | Base to load |
| ld_limit | input | 32 | Length in bytes to load |
| ld_perm | input | 3 | Permissions to load: bit 0 read, bit 1 write, bit 2 fetch |
| ld_present | input | 1 | Present flag to load |
| req_valid | input | 1 | Request strobe |
| req_idx | input | 3 | Segment index of the request |
| req_type | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_off | input | 32 | Offset within the segment |
| rsp_valid | output | 1 | Response valid |
| rsp_addr_ok | output | 1 | Address valid strobe |
| rsp_addr | output | 32 | Linear address |
| rsp_fault | output | 2 | Fault code: 0 none, 1 limit, 2 permission, 3 not present |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-response pairing;
- that an address strobe never appears together with a fault;
- that faulting responses carry a zero address;
- that legacy responses stay within 20 bits and never fault;
- that the mode register never holds code 3 and is untouched by a code-3 write.

The bench scenarios cover the rest. These are the actual address arithmetic in each mode, the 20-bit and 32-bit wrap-around, the fault priority order, the zero bases and the two kept bases in flat mode, the behaviour of invalid indices, and the same-cycle timing of mode writes and descriptor loads.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;
  localparam int SEG_AW   = 32;
  localparam int PERM_W   = 3;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_PROT   = 2'd1,
    MODE_FLAT   = 2'd2
  } xmode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_PERM   = 2'd2,
    FLT_ABSENT = 2'd3
  } fault_e;

  typedef struct packed {
    logic [SEG_AW-1:0] base;
    logic [SEG_AW-1:0] limit;
    logic [PERM_W-1:0] perm;
    logic              present;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
  import segxlat_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  seg_desc_t        ld_desc,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_desc_t        rd_desc,
  output logic             rd_hit
);
  seg_desc_t entry_q [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_entry
    logic we;
    assign we = ld_en && (ld_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  entry_q[g] <= '0;
      else if (we) entry_q[g] <= ld_desc;
    end
  end

  always_comb begin
    rd_desc = '0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_desc = entry_q[i];
    end
  end

  assign rd_hit = int'(rd_idx) < NUM_SEGS;
endmodule

// File: rtl/seg_check.sv
module seg_check
  import segxlat_pkg::*;
(
  input  xmode_e            mode,
  input  logic [1:0]        acc,
  input  seg_desc_t         desc,
  input  logic              hit,
  input  logic [SEG_AW-1:0] offset,
  output fault_e            fault
);
  logic perm_ok;
  logic over;

  always_comb begin
    case (acc)
      ACC_READ:  perm_ok = desc.perm[0];
      ACC_WRITE: perm_ok = desc.perm[1];
      ACC_FETCH: perm_ok = desc.perm[2];
      default:   perm_ok = 1'b0;
    endcase
    over = (mode == MODE_PROT) && (offset >= desc.limit);
    if (mode == MODE_LEGACY)          fault = FLT_NONE;
    else if (!hit || !desc.present)   fault = FLT_ABSENT;
    else if (!perm_ok)                fault = FLT_PERM;
    else if (over)                    fault = FLT_LIMIT;
    else                              fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import segxlat_pkg::*;
#(
  parameter int IDX_W          = 3,
  parameter int FLAT_ZERO_SEGS = 4,
  parameter int SEL_W          = 16,
  parameter int SEL_SHIFT      = 4
) (
  input  xmode_e            mode,
  input  logic [IDX_W-1:0]  idx,
  input  seg_desc_t         desc,
  input  logic              hit,
  input  logic [SEG_AW-1:0] offset,
  output logic [SEG_AW-1:0] addr
);
  localparam int LEG_W = SEL_W + SEL_SHIFT;

  logic [SEL_W-1:0]  sel;
  logic [LEG_W-1:0]  leg_sum;
  logic [SEG_AW-1:0] eff_base;

  assign sel     = hit ? desc.base[SEL_W-1:0] : '0;
  assign leg_sum = {sel, {SEL_SHIFT{1'b0}}} + LEG_W'(offset[SEL_W-1:0]);

  always_comb begin
    eff_base = desc.base;
    if (mode == MODE_FLAT && int'(idx) < FLAT_ZERO_SEGS) eff_base = '0;
    if (mode == MODE_LEGACY) addr = SEG_AW'(leg_sum);
    else                     addr = eff_base + offset;
  end
endmodule

// File: rtl/segxlat_unit.sv
module segxlat_unit
  import segxlat_pkg::*;
#(
  parameter int NUM_SEGS       = 6,
  parameter int IDX_W          = 3,
  parameter int FLAT_ZERO_SEGS = 4,
  parameter int LEG_W          = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr,
  input  logic [1:0]          mode_in,
  output logic [1:0]          mode_o,
  input  logic                ld_en,
  input  logic [IDX_W-1:0]    ld_idx,
  input  logic [SEG_AW-1:0]   ld_base,
  input  logic [SEG_AW-1:0]   ld_limit,
  input  logic [PERM_W-1:0]   ld_perm,
  input  logic                ld_present,
  input  logic                req_valid,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic [1:0]          req_type,
  input  logic [SEG_AW-1:0]   req_off,
  output logic                rsp_valid,
  output logic                rsp_addr_ok,
  output logic [SEG_AW-1:0]   rsp_addr,
  output logic [1:0]          rsp_fault
);
  localparam int SHIFT = LEG_W - 16;

  xmode_e            mode_q, mode_d;
  seg_desc_t         ld_desc, rd_desc;
  logic              rd_hit;
  fault_e            fault_c;
  logic [SEG_AW-1:0] addr_c;
  logic              v_d, ok_d;
  logic [SEG_AW-1:0] addr_d;
  fault_e            flt_d, flt_q;

  assign ld_desc = '{base: ld_base, limit: ld_limit, perm: ld_perm, present: ld_present};

  seg_desc_file #(.NUM_SEGS(NUM_SEGS), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_desc(ld_desc),
    .rd_idx(req_idx), .rd_desc(rd_desc), .rd_hit(rd_hit)
  );

  seg_check u_chk (
    .mode(mode_q), .acc(req_type), .desc(rd_desc), .hit(rd_hit),
    .offset(req_off), .fault(fault_c)
  );

  seg_addr_gen #(.IDX_W(IDX_W), .FLAT_ZERO_SEGS(FLAT_ZERO_SEGS),
                 .SEL_W(16), .SEL_SHIFT(SHIFT)) u_agen (
    .mode(mode_q), .idx(req_idx), .desc(rd_desc), .hit(rd_hit),
    .offset(req_off), .addr(addr_c)
  );

  // next-state
  always_comb begin
    mode_d = mode_q;
    if (mode_wr && mode_in != 2'd3) mode_d = xmode_e'(mode_in);
    v_d    = req_valid;
    flt_d  = req_valid ? fault_c : FLT_NONE;
    ok_d   = req_valid && (fault_c == FLT_NONE);
    addr_d = ok_d ? addr_c : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_LEGACY;
      rsp_valid   <= 1'b0;
      rsp_addr_ok <= 1'b0;
      rsp_addr    <= '0;
      flt_q       <= FLT_NONE;
    end else begin
      mode_q      <= mode_d;
      rsp_valid   <= v_d;
      rsp_addr_ok <= ok_d;
      rsp_addr    <= addr_d;
      flt_q       <= flt_d;
    end
  end

  assign mode_o    = mode_q;
  assign rsp_fault = flt_q;

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);
  p_mode_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_in == 2'd3) |=> $stable(mode_o));
  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_ok_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_addr_ok |-> (rsp_valid && rsp_fault == 2'd0));
  p_fault_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_addr == '0 && !rsp_addr_ok));
  p_legacy_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_o == 2'd0) |=> (rsp_addr_ok && rsp_addr[SEG_AW-1:LEG_W] == '0));
endmodule

// File: tb/tb_segxlat_unit.sv
`timescale 1ns/1ps
module tb_segxlat_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wr;
  logic [1:0]  mode_in, mode_o;
  logic        ld_en;
  logic [2:0]  ld_idx;
  logic [31:0] ld_base, ld_limit;
  logic [2:0]  ld_perm;
  logic        ld_present;
  logic        req_valid;
  logic [2:0]  req_idx;
  logic [1:0]  req_type;
  logic [31:0] req_off;
  logic        rsp_valid, rsp_addr_ok;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_fault;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  fault;
    logic        ok;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [31:0] m_base [6];
  logic [31:0] m_lim  [6];
  logic [2:0]  m_perm [6];
  logic        m_pres [6];
  logic [1:0]  m_mode;

  always #2.5 clk = ~clk;

  segxlat_unit dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in), .mode_o(mode_o),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base), .ld_limit(ld_limit),
    .ld_perm(ld_perm), .ld_present(ld_present), .req_valid(req_valid),
    .req_idx(req_idx), .req_type(req_type), .req_off(req_off), .rsp_valid(rsp_valid),
    .rsp_addr_ok(rsp_addr_ok), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit cond, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] idx, input logic [1:0] typ,
                                 input logic [31:0] off, input string tag);
    exp_t e;
    logic [15:0] sel;
    logic [19:0] la;
    bit granted;
    logic [31:0] b;
    e.tag = tag; e.fault = 2'd0; e.addr = '0;
    if (m_mode == 2'd0) begin
      sel = (idx < 6) ? m_base[idx][15:0] : 16'h0;
      la  = {sel, 4'h0} + {4'h0, off[15:0]};
      e.addr = {12'h0, la};
    end else begin
      if (idx >= 6 || !m_pres[idx]) e.fault = 2'd3;
      else begin
        granted = (typ == 2'd3) ? 1'b0 : m_perm[idx][typ];
        if (!granted) e.fault = 2'd2;
        else if (m_mode == 2'd1 && off >= m_lim[idx]) e.fault = 2'd1;
        if (e.fault == 2'd0) begin
          b = (m_mode == 2'd2 && idx < 4) ? 32'h0 : m_base[idx];
          e.addr = b + off;
        end
      end
    end
    e.ok = (e.fault == 2'd0);
    return e;
  endfunction

  task automatic release_edge();
    @(posedge clk); #1;
    mode_wr = 0; ld_en = 0; req_valid = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_wr = 1; mode_in = m;
    if (m != 2'd3) m_mode = m;
    release_edge();
  endtask

  task automatic load(input logic [2:0] i, input logic [31:0] b, input logic [31:0] l,
                      input logic [2:0] p, input logic pr);
    @(negedge clk);
    ld_en = 1; ld_idx = i; ld_base = b; ld_limit = l; ld_perm = p; ld_present = pr;
    if (i < 6) begin m_base[i] = b; m_lim[i] = l; m_perm[i] = p; m_pres[i] = pr; end
    release_edge();
  endtask

  task automatic issue(input logic [2:0] i, input logic [1:0] t, input logic [31:0] o,
                       input string tag);
    @(negedge clk);
    req_valid = 1; req_idx = i; req_type = t; req_off = o;
    sb_q.push_back(model(i, t, o, tag));
    release_edge();
  endtask

  // request and mode write in the same cycle: request uses the old mode (R2)
  task automatic issue_with_mode(input logic [1:0] m, input logic [2:0] i,
                                 input logic [1:0] t, input logic [31:0] o, input string tag);
    @(negedge clk);
    req_valid = 1; req_idx = i; req_type = t; req_off = o;
    mode_wr = 1; mode_in = m;
    sb_q.push_back(model(i, t, o, tag));
    if (m != 2'd3) m_mode = m;
    release_edge();
  endtask

  task automatic check_mode(input logic [1:0] m, input string tag);
    @(negedge clk);
    chk(mode_o == m, tag, mode_o, m);
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R3 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_fault == e.fault, {e.tag, " fault"}, rsp_fault, e.fault);
        chk(rsp_addr_ok == e.ok, {e.tag, " ok R3"}, rsp_addr_ok, e.ok);
        chk(rsp_addr == e.addr, {e.tag, " addr"}, rsp_addr, e.addr);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_wr = 0; mode_in = 0; ld_en = 0; ld_idx = 0; ld_base = 0;
    ld_limit = 0; ld_perm = 0; ld_present = 0; req_valid = 0; req_idx = 0;
    req_type = 0; req_off = 0; m_mode = 0;
    for (int i = 0; i < 6; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0; m_pres[i] = 0;
    end
    #12 rst_n = 1;
    @(negedge clk);
    chk(mode_o == 2'd0, "R1 reset mode", mode_o, 0);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);

    issue(0, 0, 32'h0001_1234, "R1 R4 legacy cleared desc");
    set_mode(1);
    check_mode(1, "R2 enter protected");
    issue(0, 0, 32'h0, "R1 R8 cleared desc absent");

    load(0, 32'h1000_0000, 32'h100, 3'b100, 1);
    issue(0, 2, 32'hFF, "R11 R5 load then fetch in limit");
    load(1, 32'h2000_0000, 32'h1000, 3'b011, 1);
    load(2, 32'h0000_3000, 32'h10, 3'b001, 0);
    load(3, 32'hFFFF_FFF0, 32'h100, 3'b111, 1);
    load(4, 32'h4000_0000, 32'h20, 3'b001, 1);
    load(5, 32'h5000_0000, 32'h0, 3'b011, 1);

    issue(0, 2, 32'h100, "R6 offset equal to length");
    issue(0, 0, 32'h10, "R7 read without grant");
    issue(1, 1, 32'h10, "R5 R7 write granted");
    issue(1, 2, 32'h10, "R7 fetch without grant");
    issue(2, 0, 32'hFFFF, "R8 absent beats limit");
    issue(3, 0, 32'h20, "R5 32-bit wrap");
    issue(3, 3, 32'h0, "R7 reserved type");
    issue(6, 0, 32'h0, "R10 index 6 protected");
    issue(1, 1, 32'h2000, "R6 write over length");
    issue(1, 2, 32'h2000, "R7 perm beats limit");
    issue(5, 0, 32'h0, "R6 zero length");
    load(6, 32'h1, 32'hFFFF, 3'b111, 1);
    issue(6, 0, 32'h0, "R11 load to index 6 ignored");

    set_mode(3);
    check_mode(1, "R2 code 3 ignored");
    set_mode(2);
    check_mode(2, "R2 enter flat");
    issue(1, 0, 32'h0001_2345, "R9 flat zero base no limit");
    issue(4, 0, 32'h100, "R9 flat kept base seg4");
    issue(5, 1, 32'h8, "R9 flat kept base seg5");
    issue(2, 0, 32'h0, "R9 R8 flat absent");
    issue(0, 0, 32'h0, "R9 R7 flat perm");
    issue(7, 0, 32'h0, "R10 index 7 flat");

    issue_with_mode(2'd0, 2, 0, 32'h0, "R2 same-cycle write uses old mode");
    check_mode(0, "R2 back to legacy");
    load(4, 32'h0000_F000, 32'h0, 3'b000, 0);
    issue(4, 0, 32'h0003_FFFF, "R4 legacy top of space");
    load(5, 32'h0000_FFFF, 32'h0, 3'b000, 1);
    issue(5, 1, 32'h20, "R4 legacy 20-bit wrap");
    issue(2, 3, 32'h55, "R4 legacy no checks");
    issue(7, 0, 32'hABCD, "R10 legacy index 7 selector 0");

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R3 all responses seen", sb_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule